// File: doc/BRIEF.md
# Cross-Domain Mailbox Register Bank

This block lets a slow, asynchronous host expansion bus hand 16-bit words to a local microcontroller that runs on a faster main clock. Each mailbox has its own host bus address. A host write to that address stores the word and raises the mailbox's "new data" flag in the main clock domain. The microcontroller polls the flags and reads the words through a small asynchronous register port. It then acknowledges each flag by writing a one to that flag's bit.

The set path is built so that a slow address comparator cannot glitch. The whole set condition (operation active, write strobe low, address match) is registered on the host command strobe before it is used anywhere. That register drives a main-clock synchronizer directly, with no logic in between. An edge-detect flop after the synchronizer turns each captured write into one set pulse. The data word is captured on the same strobe edge and copied into a main-domain holding register on that pulse. A raised flag therefore always comes with the word that raised it.

Top module: `mbox_xdom`

## Requirements
- R1: After reset, every flag, every mailbox word and the local read data are zero.
- R2: A host access with `bus_op_i` high and `bus_wr_ni` low, captured on a rising edge of `bus_cmd_i` with address `HOST_BASE + k`, sets flag k (bit k of `flags_o`) and loads the data into mailbox k. A repeat write to the same mailbox takes effect only after a capture edge that has no write to that mailbox.
- R3: When flag k rises, `mbox_data_o[k*16 +: 16]` already holds the word from the write that raised it. Mailbox words change only on a set event.
- R4: A host access with `bus_wr_ni` high, or with `bus_op_i` low, changes no flag and no mailbox word, even at a mailbox address.
- R5: A host write to an address that is not a mailbox address leaves all flags and words unchanged, even right after a write to a mailbox.
- R6: The set event passes through a 3-stage synchronizer and an edge flop. Flag k is still low after the third rising `clk_i` edge that follows the capture edge, and high after the fourth. Each captured write makes exactly one single-cycle set pulse.
- R7: A local write to address 15 clears every flag whose bit in `loc_wdata_i` is 1. Flags whose bit is 0 are left unchanged.
- R8: When a set pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A local read returns the mailbox k word at address k (k < 4). At address 15 it returns the flags in bits 3:0 with zeros above. Any other address returns zero.
- R10: Local strobes pass through 2 synchronizer flops and act once, on their rising edge. Holding `loc_wr_i` high does not clear a flag that is set later, and `loc_rdata_o` changes only on a read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| bus_cmd_i | input | 1 | Host command strobe; its rising edge captures the access |
| bus_op_i | input | 1 | Host operation active |
| bus_wr_ni | input | 1 | Host write strobe, active low |
| bus_addr_i | input | 4 | Host register address |
| bus_data_i | input | 16 | Host write data |
| loc_addr_i | input | 4 | Local register address |
| loc_wdata_i | input | 16 | Local write data |
| loc_rd_i | input | 1 | Local read strobe, asynchronous, active high |
| loc_wr_i | input | 1 | Local write strobe, asynchronous, active high |
| loc_rdata_o | output | 16 | Local read data, updated on a read edge |
| mbox_data_o | output | 64 | Mailbox words, mailbox k in bits k*16 +: 16 |
| flags_o | output | 4 | New-data flags, bit k for mailbox k |

## Verification
The set path is driven with writes to every mailbox address and with three kinds of access that must not set anything. These are reads and inactive cycles aimed at a mailbox address, and writes to a non-mailbox address made right after a mailbox write, which is the stale-decode case. Comparing them shows whether the flag follows the full registered condition or only part of it. The flag is sampled cycle by cycle around the fourth main clock edge, which pins down the synchronizer depth. A clear is timed to land on the same cycle as a set to check which one wins. A local write strobe held high across a later set shows whether local strobes act on their edge or on their level.

// File: rtl/mbox_xdom_pkg.sv
package mbox_xdom_pkg;
  localparam int unsigned DEF_N_MBOX      = 4;
  localparam int unsigned DEF_DATA_W      = 16;
  localparam int unsigned DEF_HOST_AW     = 4;
  localparam int unsigned DEF_HOST_BASE   = 4;
  localparam int unsigned DEF_LOC_AW      = 4;
  localparam int unsigned DEF_FLAG_LADDR  = 15;
  localparam int unsigned DEF_SYNC_STAGES = 3;
  localparam int unsigned DEF_STB_STAGES  = 2;
endpackage

// File: rtl/mbox_bus_capture.sv
module mbox_bus_capture #(
  parameter int unsigned N_MBOX    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned HOST_AW   = 4,
  parameter int unsigned HOST_BASE = 4
) (
  input  logic                       cmd_i,
  input  logic                       rst_ni,
  input  logic                       op_i,
  input  logic                       wr_ni,
  input  logic [HOST_AW-1:0]         addr_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [N_MBOX-1:0]          set_q_o,
  output logic [N_MBOX*DATA_W-1:0]   data_q_o
);
  for (genvar k = 0; k < N_MBOX; k++) begin : g_mbox
    localparam logic [HOST_AW-1:0] MY_ADDR = HOST_AW'(HOST_BASE + k);
    logic              hit;
    logic              set_q;
    logic [DATA_W-1:0] data_q;

    // full term, decode included, registered before any use
    assign hit = op_i & ~wr_ni & (addr_i == MY_ADDR);

    always_ff @(posedge cmd_i or negedge rst_ni) begin
      if (!rst_ni) begin
        set_q  <= 1'b0;
        data_q <= '0;
      end else begin
        set_q <= hit;
        if (hit) data_q <= data_i;
      end
    end

    assign set_q_o[k]                   = set_q;
    assign data_q_o[k*DATA_W +: DATA_W] = data_q;
  end
endmodule

// File: rtl/xdom_edge_sync.sv
module xdom_edge_sync #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      edge_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      edge_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~edge_q;
endmodule

// File: rtl/mbox_loc_regs.sv
module mbox_loc_regs #(
  parameter int unsigned N_MBOX     = 4,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LOC_AW     = 4,
  parameter int unsigned FLAG_LADDR = 15
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_MBOX-1:0]         set_pulse_i,
  input  logic [N_MBOX*DATA_W-1:0]  cap_data_i,
  input  logic                      wr_pulse_i,
  input  logic                      rd_pulse_i,
  input  logic [LOC_AW-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [N_MBOX-1:0]         clr_o,
  output logic [N_MBOX-1:0]         flags_o,
  output logic [N_MBOX*DATA_W-1:0]  hold_o,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam logic [LOC_AW-1:0] FLAG_A = LOC_AW'(FLAG_LADDR);

  logic [N_MBOX-1:0] flags_q;
  logic [DATA_W-1:0] hold_q [N_MBOX];
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rnext;

  if (DATA_W > N_MBOX) begin : g_unused
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:N_MBOX];
  end

  always_comb begin
    clr_o = '0;
    if (wr_pulse_i && addr_i == FLAG_A) clr_o = wdata_i[N_MBOX-1:0];
  end

  always_comb begin
    rnext = '0;
    if (addr_i == FLAG_A) begin
      rnext[N_MBOX-1:0] = flags_q;
    end else begin
      for (int k = 0; k < N_MBOX; k++)
        if (addr_i == LOC_AW'(k)) rnext = hold_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      rdata_q <= '0;
      for (int k = 0; k < N_MBOX; k++) hold_q[k] <= '0;
    end else begin
      // set has priority over clear
      flags_q <= (flags_q & ~clr_o) | set_pulse_i;
      for (int k = 0; k < N_MBOX; k++)
        if (set_pulse_i[k]) hold_q[k] <= cap_data_i[k*DATA_W +: DATA_W];
      if (rd_pulse_i) rdata_q <= rnext;
    end
  end

  for (genvar k = 0; k < N_MBOX; k++) begin : g_hold
    assign hold_o[k*DATA_W +: DATA_W] = hold_q[k];
  end

  assign flags_o = flags_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mbox_xdom.sv
module mbox_xdom
  import mbox_xdom_pkg::*;
#(
  parameter int unsigned N_MBOX      = DEF_N_MBOX,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned HOST_AW     = DEF_HOST_AW,
  parameter int unsigned HOST_BASE   = DEF_HOST_BASE,
  parameter int unsigned LOC_AW      = DEF_LOC_AW,
  parameter int unsigned FLAG_LADDR  = DEF_FLAG_LADDR,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned STB_STAGES  = DEF_STB_STAGES
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_cmd_i,
  input  logic                      bus_op_i,
  input  logic                      bus_wr_ni,
  input  logic [HOST_AW-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]         bus_data_i,
  input  logic [LOC_AW-1:0]         loc_addr_i,
  input  logic [DATA_W-1:0]         loc_wdata_i,
  input  logic                      loc_rd_i,
  input  logic                      loc_wr_i,
  output logic [DATA_W-1:0]         loc_rdata_o,
  output logic [N_MBOX*DATA_W-1:0]  mbox_data_o,
  output logic [N_MBOX-1:0]         flags_o
);
  logic [N_MBOX-1:0]        set_q;
  logic [N_MBOX*DATA_W-1:0] cap_data;
  logic [N_MBOX-1:0]        set_pulse;
  logic [N_MBOX-1:0]        clr;
  logic                     rd_pulse;
  logic                     wr_pulse;

  mbox_bus_capture #(
    .N_MBOX(N_MBOX), .DATA_W(DATA_W), .HOST_AW(HOST_AW), .HOST_BASE(HOST_BASE)
  ) u_cap (
    .cmd_i(bus_cmd_i), .rst_ni(rst_ni), .op_i(bus_op_i), .wr_ni(bus_wr_ni),
    .addr_i(bus_addr_i), .data_i(bus_data_i),
    .set_q_o(set_q), .data_q_o(cap_data)
  );

  for (genvar k = 0; k < N_MBOX; k++) begin : g_set_sync
    xdom_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(set_q[k]), .pulse_o(set_pulse[k])
    );
  end

  xdom_edge_sync #(.STAGES(STB_STAGES)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(loc_rd_i), .pulse_o(rd_pulse)
  );

  xdom_edge_sync #(.STAGES(STB_STAGES)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(loc_wr_i), .pulse_o(wr_pulse)
  );

  mbox_loc_regs #(
    .N_MBOX(N_MBOX), .DATA_W(DATA_W), .LOC_AW(LOC_AW), .FLAG_LADDR(FLAG_LADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_pulse_i(set_pulse), .cap_data_i(cap_data),
    .wr_pulse_i(wr_pulse), .rd_pulse_i(rd_pulse),
    .addr_i(loc_addr_i), .wdata_i(loc_wdata_i),
    .clr_o(clr), .flags_o(flags_o), .hold_o(mbox_data_o), .rdata_o(loc_rdata_o)
  );
endmodule

// File: rtl/mbox_xdom_chk.sv
module mbox_xdom_chk #(
  parameter int unsigned N_MBOX = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_MBOX-1:0]         set_pulse_i,
  input logic [N_MBOX-1:0]         clr_i,
  input logic                      rd_pulse_i,
  input logic [N_MBOX-1:0]         flags_i,
  input logic [N_MBOX*DATA_W-1:0]  mbox_data_i,
  input logic [DATA_W-1:0]         rdata_i
);
  for (genvar k = 0; k < N_MBOX; k++) begin : g_chk
    assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_pulse_i[k] |=> flags_i[k]);
    assert_data_only_on_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !set_pulse_i[k] |=> $stable(mbox_data_i[k*DATA_W +: DATA_W]));
    assert_flag_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_pulse_i[k] && !clr_i[k]) |=> $stable(flags_i[k]));
    assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_pulse_i[k] |=> !set_pulse_i[k]);
    assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_pulse_i[k]) |=> !flags_i[k]);
    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && set_pulse_i[k]) |=> flags_i[k]);
  end

  assert_rdata_edge_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_pulse_i |=> $stable(rdata_i));
endmodule

bind mbox_xdom mbox_xdom_chk #(.N_MBOX(N_MBOX), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_pulse_i(set_pulse), .clr_i(clr),
  .rd_pulse_i(rd_pulse), .flags_i(flags_o), .mbox_data_i(mbox_data_o),
  .rdata_i(loc_rdata_o)
);

// File: tb/mbox_xdom_tb_top.sv
module mbox_xdom_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] FLAG_A = 4'hF;
  localparam logic [3:0] HBASE  = 4'h4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_cmd = 1'b0, bus_op = 1'b0, bus_wr_n = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic [3:0]  loc_addr = '0;
  logic [15:0] loc_wdata = '0;
  logic        loc_rd = 1'b0, loc_wr = 1'b0;
  logic [15:0] loc_rdata;
  logic [63:0] mbox_data;
  logic [3:0]  flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_xdom dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_cmd_i(bus_cmd), .bus_op_i(bus_op), .bus_wr_ni(bus_wr_n),
    .bus_addr_i(bus_addr), .bus_data_i(bus_data),
    .loc_addr_i(loc_addr), .loc_wdata_i(loc_wdata),
    .loc_rd_i(loc_rd), .loc_wr_i(loc_wr), .loc_rdata_o(loc_rdata),
    .mbox_data_o(mbox_data), .flags_o(flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mb(input int k);
    return mbox_data[k*16 +: 16];
  endfunction

  // capture edge with no write, ends the bus access
  task automatic bus_idle_edge();
    @(negedge clk);
    bus_op = 1'b0; bus_wr_n = 1'b1;
    #1 bus_cmd = 1'b1;
    @(negedge clk);
    bus_cmd = 1'b0;
  endtask

  task automatic bus_access(input logic op, input logic wr_n, input logic [3:0] a,
                            input logic [15:0] d);
    @(negedge clk);
    bus_op = op; bus_wr_n = wr_n; bus_addr = a; bus_data = d;
    #1 bus_cmd = 1'b1;
    @(negedge clk);
    bus_cmd = 1'b0;
    @(negedge clk);
    bus_idle_edge();
    repeat (6) @(negedge clk);
  endtask

  task automatic loc_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    loc_addr = a; loc_wdata = d; loc_wr = 1'b1;
    repeat (5) @(negedge clk);
    loc_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic loc_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    loc_addr = a; loc_rd = 1'b1;
    repeat (5) @(negedge clk);
    d = loc_rdata;
    loc_rd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 flags", 32'(flags), 32'h0);
    check("R1 mailbox words", mbox_data[31:0] | mbox_data[63:32], 32'h0);
    check("R1 read data", 32'(loc_rdata), 32'h0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    bus_access(1'b1, 1'b0, HBASE, 16'hA5A5);
    check("R2 flag0 set", 32'(flags), 32'h1);
    check("R2 mailbox0 word", 32'(mb(0)), 32'hA5A5);
    loc_read(4'd0, d);
    check("R9 read mailbox0", 32'(d), 32'hA5A5);
    loc_read(FLAG_A, d);
    check("R9 read flag register", 32'(d), 32'h1);
  endtask

  task automatic t_all();
    logic [15:0] d;
    for (int k = 0; k < 4; k++) bus_access(1'b1, 1'b0, HBASE + 4'(k), 16'hC0D0 + 16'(k));
    check("R2 all flags", 32'(flags), 32'hF);
    for (int k = 0; k < 4; k++) begin
      loc_read(4'(k), d);
      check("R9 read each mailbox", 32'(d), 32'hC0D0 + 32'(k));
    end
    loc_read(4'd7, d);
    check("R9 unmapped address reads zero", 32'(d), 32'h0);
  endtask

  task automatic t_clear();
    loc_write(FLAG_A, 16'h0005);
    check("R7 partial clear", 32'(flags), 32'hA);
    loc_write(FLAG_A, 16'h000A);
    check("R7 clear rest", 32'(flags), 32'h0);
  endtask

  task automatic t_ignored();
    bus_access(1'b1, 1'b1, HBASE + 4'd2, 16'h1111);
    check("R4 host read no flag", 32'(flags), 32'h0);
    bus_access(1'b0, 1'b0, HBASE + 4'd2, 16'h2222);
    check("R4 inactive op no flag", 32'(flags), 32'h0);
    check("R4 mailbox2 unchanged", 32'(mb(2)), 32'hC0D2);
  endtask

  task automatic t_stale();
    bus_access(1'b1, 1'b0, HBASE + 4'd3, 16'h3C3C);
    loc_write(FLAG_A, 16'h0008);
    // write to a non-mailbox address directly after the mailbox write
    @(negedge clk);
    bus_op = 1'b1; bus_wr_n = 1'b0; bus_addr = HBASE + 4'd3; bus_data = 16'h7777;
    #1 bus_cmd = 1'b1;
    @(negedge clk);
    bus_cmd = 1'b0;
    bus_addr = 4'h0; bus_data = 16'hDEAD;
    #1 bus_cmd = 1'b1;
    @(negedge clk);
    bus_cmd = 1'b0;
    bus_idle_edge();
    repeat (6) @(negedge clk);
    check("R5 one flag from back-to-back pair", 32'(flags), 32'h8);
    check("R5 mailbox3 keeps mailbox write", 32'(mb(3)), 32'h7777);
    loc_write(FLAG_A, 16'h0008);
    bus_access(1'b1, 1'b0, 4'h9, 16'hBEEF);
    check("R5 non-mailbox write no flag", 32'(flags), 32'h0);
    check("R5 mailbox3 unchanged", 32'(mb(3)), 32'h7777);
  endtask

  task automatic t_latency();
    @(negedge clk);
    bus_op = 1'b1; bus_wr_n = 1'b0; bus_addr = HBASE + 4'd1; bus_data = 16'h5A01;
    #1 bus_cmd = 1'b1;
    @(negedge clk);
    bus_cmd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R6 flag low after third edge", 32'(flags), 32'h0);
    @(negedge clk);
    check("R6 flag high after fourth edge", 32'(flags), 32'h2);
    check("R3 word present with flag", 32'(mb(1)), 32'h5A01);
    bus_idle_edge();
    repeat (6) @(negedge clk);
    loc_write(FLAG_A, 16'h0002);
    check("R6 flag cleared", 32'(flags), 32'h0);
  endtask

  task automatic t_set_wins();
    bus_access(1'b1, 1'b0, HBASE, 16'h0F0F);
    @(negedge clk);
    bus_op = 1'b1; bus_wr_n = 1'b0; bus_addr = HBASE + 4'd1; bus_data = 16'h1234;
    #1 bus_cmd = 1'b1;
    @(negedge clk);
    bus_cmd = 1'b0;
    loc_addr = FLAG_A; loc_wdata = 16'h0003; loc_wr = 1'b1;
    repeat (5) @(negedge clk);
    loc_wr = 1'b0;
    bus_idle_edge();
    repeat (6) @(negedge clk);
    check("R8 set wins same cycle", 32'(flags), 32'h2);
    check("R8 mailbox1 word", 32'(mb(1)), 32'h1234);
    loc_write(FLAG_A, 16'h0002);
  endtask

  task automatic t_strobe_hold();
    logic [15:0] d;
    bus_access(1'b1, 1'b0, HBASE, 16'h4444);
    @(negedge clk);
    loc_addr = FLAG_A; loc_wdata = 16'h0001; loc_wr = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 clear on wr edge", 32'(flags), 32'h0);
    bus_access(1'b1, 1'b0, HBASE, 16'h5555);
    check("R10 held strobe does not re-clear", 32'(flags), 32'h1);
    loc_wr = 1'b0;
    repeat (4) @(negedge clk);
    loc_read(4'd0, d);
    bus_access(1'b1, 1'b0, HBASE + 4'd2, 16'h6666);
    check("R10 read data steady without read edge", 32'(loc_rdata), 32'h5555);
    loc_write(FLAG_A, 16'h0005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_all();
    t_clear();
    t_ignored();
    t_stale();
    t_latency();
    t_set_wins();
    t_strobe_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule